// File: doc/BRIEF.md
# Dual-Channel Serial I/Q Output Framer

This block turns parallel I/Q sample pairs from two receive channels, A and B, into bit-serial streams. It also produces a frame-sync strobe next to each stream. When a one-cycle sample-ready strobe arrives while the framer is idle, the block captures four words: A's I and Q and B's I and Q. It also captures the configuration: the strobe mode, the routing select and the word precision. It then shifts the words out most significant bit first, with the I word of each channel ahead of its Q word. All outputs change on the rising edge of the serial clock.

With dual routing, channel A leaves on line 0 and channel B on line 1 in parallel. With single routing, line 0 carries A and then B back to back, and line 1 stays quiet. The 2-bit strobe mode sets the frame-sync pattern:
- a single pulse before the frame,
- a pulse before each channel,
- a pulse before every word, or
- a level held over the whole frame.

A sample-ready strobe that arrives while a frame is still running is dropped, and it is reported on a one-cycle error output.

Top module: `iqSerialFramer`

## Requirements
- R1: With `dualOut`=1, channel A (I then Q) goes out on `serOut0` and channel B (I then Q) on `serOut1` in the same cycles, and `fsync1` follows `fsync0`. With `dualOut`=0, `serOut0` carries A.I, A.Q, B.I, B.Q in that order, and `serOut1` and `fsync1` stay low.
- R2: With `wide24`=1 each word is bits 23..0 of its input. With `wide24`=0 each word is bits 15..0. Every word is sent most significant bit first.
- R3: A strobe sampled at a rising edge while idle starts a frame. The cycle after that edge is a lead cycle, with data low and frame sync high in every mode. The first data bit comes in the cycle after the lead cycle.
- R4: Mode `modeSel`=2'b00 gives exactly one frame-sync pulse, in the lead cycle.
- R5: Mode 2'b01 with `dualOut`=1 matches mode 2'b00. With `dualOut`=0 it gives a second pulse in the cycle that carries the last bit of A's Q word, just before B's first bit.
- R6: Mode 2'b10 gives a pulse in the cycle just before the first bit of each word: 2 pulses per line with dual routing and 4 with single routing.
- R7: Mode 2'b11 holds frame sync high from the lead cycle through the cycle of the last data bit, and drops it in the next cycle.
- R8: A strobe sampled while a frame is running is ignored and leaves the frame unchanged. `errFlag` is then high for exactly the next cycle. At all other times `errFlag` is low.
- R9: While no frame is running, `serOut0`, `serOut1`, `fsync0` and `fsync1` are low. A new frame may start in the first idle cycle after the last bit.
- R10: Words and configuration are captured when the strobe is accepted. Changes to those inputs during the frame do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleRdy | input | 1 | New sample set available |
| chAI | input | 24 | Channel A in-phase word |
| chAQ | input | 24 | Channel A quadrature word |
| chBI | input | 24 | Channel B in-phase word |
| chBQ | input | 24 | Channel B quadrature word |
| modeSel | input | 2 | Frame-sync pattern select |
| dualOut | input | 1 | 1: one line per channel; 0: both channels on line 0 |
| wide24 | input | 1 | 1: 24-bit words; 0: 16-bit words |
| serOut0 | output | 1 | Serial data line 0 |
| serOut1 | output | 1 | Serial data line 1 |
| fsync0 | output | 1 | Frame sync for line 0 |
| fsync1 | output | 1 | Frame sync for line 1 |
| errFlag | output | 1 | Strobe dropped during a running frame |

## Verification
Cycle k counts from the edge that accepts the strobe. Cycle 0 is the lead cycle, and for j≥1 cycle j carries bit j-1 of the frame. Data and frame sync are due in that same cycle, and an overrun error is due one cycle after the edge that sampled the late strobe.

The bench samples every output at the falling edge of each cycle from 0 through one past the last bit. It compares each sample with a value that a bench function computes from k, the word width, the routing and the mode. The bench also:
- rewrites all inputs after acceptance,
- injects late strobes,
- starts frames in the first idle cycle.

// File: rtl/framerPkg.sv
package framerPkg;
  parameter int WIDE_W    = 24;
  parameter int NARROW_W  = 16;
  parameter int NUM_WORDS = 4;
  localparam int BIT_IDX_W  = $clog2(WIDE_W);
  localparam int WORD_IDX_W = $clog2(NUM_WORDS);

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT} frState_t;

  typedef struct packed {
    logic                  load;
    logic                  busy;
    logic                  shiftOn;
    logic                  dual;
    logic [WORD_IDX_W-1:0] wordIdx;
    logic [BIT_IDX_W-1:0]  bitIdx;
  } dpCtl_t;
endpackage

// File: rtl/framerCtl.sv
module framerCtl
  import framerPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleRdy,
  input  logic [1:0] modeSel,
  input  logic       dualOut,
  input  logic       wide24,
  output dpCtl_t     ctl,
  output logic       fsync0,
  output logic       fsync1,
  output logic       errFlag
);
  frState_t              state;
  logic [1:0]            cfgMode;
  logic                  cfgDual;
  logic                  cfgWide;
  logic [WORD_IDX_W-1:0] wordIdx;
  logic [BIT_IDX_W-1:0]  bitIdx;
  logic [WORD_IDX_W-1:0] lastWord;
  logic [BIT_IDX_W-1:0]  topBit;
  logic                  wordEnd;
  logic                  fsRaw;

  assign lastWord = cfgDual ? WORD_IDX_W'(NUM_WORDS / 2 - 1) : WORD_IDX_W'(NUM_WORDS - 1);
  assign topBit   = cfgWide ? BIT_IDX_W'(WIDE_W - 1) : BIT_IDX_W'(NARROW_W - 1);
  assign wordEnd  = (state == ST_SHIFT) && (bitIdx == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cfgMode <= '0;
      cfgDual <= 1'b0;
      cfgWide <= 1'b0;
      wordIdx <= '0;
      bitIdx  <= '0;
      errFlag <= 1'b0;
    end else begin
      errFlag <= sampleRdy && (state != ST_IDLE);
      case (state)
        ST_IDLE: begin
          if (sampleRdy) begin
            state   <= ST_LEAD;
            cfgMode <= modeSel;
            cfgDual <= dualOut;
            cfgWide <= wide24;
          end
        end
        ST_LEAD: begin
          state   <= ST_SHIFT;
          wordIdx <= '0;
          bitIdx  <= topBit;
        end
        ST_SHIFT: begin
          if (bitIdx == '0) begin
            if (wordIdx == lastWord) begin
              state <= ST_IDLE;
            end else begin
              wordIdx <= wordIdx + 1'b1;
              bitIdx  <= topBit;
            end
          end else begin
            bitIdx <= bitIdx - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (cfgMode)
      2'd0:    fsRaw = (state == ST_LEAD);
      2'd1:    fsRaw = (state == ST_LEAD) || (!cfgDual && wordEnd && wordIdx == WORD_IDX_W'(1));
      2'd2:    fsRaw = (state == ST_LEAD) || (wordEnd && wordIdx != lastWord);
      default: fsRaw = (state != ST_IDLE);
    endcase
  end

  assign fsync0 = fsRaw;
  assign fsync1 = fsRaw && cfgDual;

  always_comb begin
    ctl.load    = (state == ST_IDLE) && sampleRdy;
    ctl.busy    = (state != ST_IDLE);
    ctl.shiftOn = (state == ST_SHIFT);
    ctl.dual    = cfgDual;
    ctl.wordIdx = wordIdx;
    ctl.bitIdx  = bitIdx;
  end
endmodule

// File: rtl/framerDp.sv
module framerDp
  import framerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [WIDE_W-1:0] chAI,
  input  logic [WIDE_W-1:0] chAQ,
  input  logic [WIDE_W-1:0] chBI,
  input  logic [WIDE_W-1:0] chBQ,
  output logic              serOut0,
  output logic              serOut1
);
  logic [WIDE_W-1:0]     inWord  [NUM_WORDS];
  logic [WIDE_W-1:0]     wordReg [NUM_WORDS];
  logic [WORD_IDX_W-1:0] sel1;

  assign inWord[0] = chAI;
  assign inWord[1] = chAQ;
  assign inWord[2] = chBI;
  assign inWord[3] = chBQ;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN)         wordReg[w] <= '0;
      else if (ctl.load) wordReg[w] <= inWord[w];
    end
  end

  assign sel1    = WORD_IDX_W'(NUM_WORDS / 2) + ctl.wordIdx;
  assign serOut0 = ctl.busy && ctl.shiftOn && wordReg[ctl.wordIdx][ctl.bitIdx];
  assign serOut1 = ctl.busy && ctl.shiftOn && ctl.dual && wordReg[sel1][ctl.bitIdx];
endmodule

// File: rtl/iqSerialFramer.sv
module iqSerialFramer
  import framerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleRdy,
  input  logic [WIDE_W-1:0] chAI,
  input  logic [WIDE_W-1:0] chAQ,
  input  logic [WIDE_W-1:0] chBI,
  input  logic [WIDE_W-1:0] chBQ,
  input  logic [1:0]        modeSel,
  input  logic              dualOut,
  input  logic              wide24,
  output logic              serOut0,
  output logic              serOut1,
  output logic              fsync0,
  output logic              fsync1,
  output logic              errFlag
);
  dpCtl_t ctlStrb;

  framerCtl uCtl (
    .clk(clk), .rstN(rstN), .sampleRdy(sampleRdy), .modeSel(modeSel),
    .dualOut(dualOut), .wide24(wide24), .ctl(ctlStrb),
    .fsync0(fsync0), .fsync1(fsync1), .errFlag(errFlag)
  );

  framerDp uDp (
    .clk(clk), .rstN(rstN), .ctl(ctlStrb),
    .chAI(chAI), .chAQ(chAQ), .chBI(chBI), .chBQ(chBQ),
    .serOut0(serOut0), .serOut1(serOut1)
  );
endmodule

// File: rtl/iqSerialFramerChk.sv
module iqSerialFramerChk (
  input logic clk,
  input logic rstN,
  input logic sampleRdy,
  input logic busy,
  input logic cfgDual,
  input logic serOut0,
  input logic serOut1,
  input logic fsync0,
  input logic fsync1,
  input logic errFlag
);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!serOut0 && !serOut1 && !fsync0 && !fsync1));

  p_late_strobe_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sampleRdy && busy) |=> errFlag);

  p_flag_needs_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> $past(busy && sampleRdy));

  p_line1_quiet_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cfgDual) |-> (!serOut1 && !fsync1));

  p_fs_mirror_dual_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cfgDual) |-> (fsync1 == fsync0));

  p_lead_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (fsync0 && !serOut0));
endmodule

bind iqSerialFramer iqSerialFramerChk chk (
  .clk(clk), .rstN(rstN), .sampleRdy(sampleRdy), .busy(ctlStrb.busy),
  .cfgDual(ctlStrb.dual), .serOut0(serOut0), .serOut1(serOut1),
  .fsync0(fsync0), .fsync1(fsync1), .errFlag(errFlag)
);

// File: tb/iqSerialFramer_test.sv
module iqSerialFramer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleRdy = 1'b0;
  logic [23:0] chAI = '0, chAQ = '0, chBI = '0, chBQ = '0;
  logic [1:0] modeSel = '0;
  logic dualOut = 1'b0, wide24 = 1'b0;
  logic serOut0, serOut1, fsync0, fsync1, errFlag;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  iqSerialFramer uut (
    .clk(clk), .rstN(rstN), .sampleRdy(sampleRdy),
    .chAI(chAI), .chAQ(chAQ), .chBI(chBI), .chBQ(chBQ),
    .modeSel(modeSel), .dualOut(dualOut), .wide24(wide24),
    .serOut0(serOut0), .serOut1(serOut1), .fsync0(fsync0),
    .fsync1(fsync1), .errFlag(errFlag)
  );

  task automatic chk(input string req, input logic act, input logic exp, input int k);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, k, act, exp);
    end
  endtask

  function automatic logic expFs(int k, int fl, int w, int md, logic dl);
    if (k > fl) return 1'b0;
    case (md)
      0:       return k == 0;
      1:       return dl ? (k == 0) : (k == 0 || k == 2 * w);
      2:       return (k % w == 0) && (k < fl);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic expData(int line, int k, int fl, int w, logic dl,
                                   logic [23:0] a0, logic [23:0] a1,
                                   logic [23:0] b0, logic [23:0] b1);
    logic [23:0] wsel;
    int j, wi;
    if (k == 0 || k > fl) return 1'b0;
    if (line == 1 && !dl) return 1'b0;
    j  = k - 1;
    wi = j / w + ((line == 1) ? 2 : 0);
    case (wi)
      0: wsel = a0;
      1: wsel = a1;
      2: wsel = b0;
      default: wsel = b1;
    endcase
    return wsel[w - 1 - (j % w)];
  endfunction

  function automatic string modeTag(int md);
    case (md)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Starts at a falling edge while idle; returns at the falling edge of cycle fl+1.
  task automatic runFrame(input int md, input logic dl, input logic wd,
                          input logic [23:0] a0, input logic [23:0] a1,
                          input logic [23:0] b0, input logic [23:0] b1,
                          input int errAt);
    int w, fl;
    w  = wd ? 24 : 16;
    fl = (dl ? 2 : 4) * w;
    chAI = a0; chAQ = a1; chBI = b0; chBQ = b1;
    modeSel = 2'(md); dualOut = dl; wide24 = wd;
    sampleRdy = 1'b1;
    @(negedge clk);
    sampleRdy = 1'b0;
    for (int k = 0; k <= fl + 1; k++) begin
      string tg;
      tg = (k == 0) ? {modeTag(md), " R3"} : (k > fl ? "R9" : modeTag(md));
      chk({tg, " fsync0"}, fsync0, expFs(k, fl, w, md, dl), k);
      chk({tg, " R1 fsync1"}, fsync1, dl ? expFs(k, fl, w, md, dl) : 1'b0, k);
      chk("R1 R2 R10 serOut0", serOut0, expData(0, k, fl, w, dl, a0, a1, b0, b1), k);
      chk("R1 R2 R10 serOut1", serOut1, expData(1, k, fl, w, dl, a0, a1, b0, b1), k);
      chk("R8 errFlag", errFlag, (errAt >= 0 && k == errAt + 1), k);
      if (k == 1) begin
        chAI = $urandom; chAQ = $urandom; chBI = $urandom; chBQ = $urandom;
        modeSel = 2'($urandom); dualOut = 1'($urandom); wide24 = 1'($urandom);
      end
      if (k <= fl) begin
        sampleRdy = (k == errAt);
        @(negedge clk);
      end
    end
    sampleRdy = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R9 idle fsync0", fsync0, 1'b0, -1);
      chk("R9 idle serOut0", serOut0, 1'b0, -1);
      chk("R8 idle errFlag", errFlag, 1'b0, -1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R9 reset serOut0", serOut0, 1'b0, -1);
    chk("R9 reset fsync0", fsync0, 1'b0, -1);
    chk("R8 reset errFlag", errFlag, 1'b0, -1);
    rstN = 1'b1;
    idle(2);
    // directed: every mode, routing and width
    for (int md = 0; md < 4; md++)
      for (int dl = 0; dl < 2; dl++)
        for (int wd = 0; wd < 2; wd++) begin
          runFrame(md, 1'(dl), 1'(wd), 24'hA5F00F, 24'h81C3E7, 24'h123456, 24'hFEDCBA, -1);
          idle(1);
        end
    // corner: all ones / all zeros words, upper bits must not leak in 16-bit mode
    runFrame(2, 1'b0, 1'b0, 24'hFF0000, 24'h00FFFF, 24'hFFFFFF, 24'h000000, -1);
    // back-to-back start in the first idle cycle (R9)
    runFrame(1, 1'b0, 1'b1, 24'h800001, 24'h7FFFFE, 24'hC00003, 24'h3FFFFC, -1);
    runFrame(3, 1'b1, 1'b0, 24'h00ABCD, 24'h001234, 24'h00F0F0, 24'h000F0F, -1);
    // late strobes: first data bit, middle, last bit (R8)
    runFrame(0, 1'b1, 1'b1, 24'h135790, 24'h2468AC, 24'hDEADBE, 24'hCAFEF0, 1);
    runFrame(3, 1'b0, 1'b0, 24'h135790, 24'h2468AC, 24'hDEADBE, 24'hCAFEF0, 17);
    runFrame(2, 1'b1, 1'b0, 24'h135790, 24'h2468AC, 24'hDEADBE, 24'hCAFEF0, 32);
    idle(2);
    // constrained random frames
    for (int n = 0; n < 40; n++) begin
      int md, fl, ea;
      logic dl, wd;
      md = $urandom_range(3);
      dl = 1'($urandom);
      wd = 1'($urandom);
      fl = (dl ? 2 : 4) * (wd ? 24 : 16);
      ea = ($urandom_range(3) == 0) ? $urandom_range(fl, 1) : -1;
      runFrame(md, dl, wd, 24'($urandom), 24'($urandom), 24'($urandom), 24'($urandom), ea);
      if ($urandom_range(1) == 1) idle($urandom_range(3, 1));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule